// File: doc/BRIEF.md
# Violation MSI Trigger Register Block

This block is the error-reporting register slice of a memory-protection checker. It stores the violation configuration word and the message-signaled interrupt target address, all reachable through a plain 32-bit register port with a combinational read path. A stored lock bit freezes that state until reset.

When the checker raises its violation line and both the interrupt enable and the MSI enable are set, the block issues one 32-bit memory write on a valid/ready request port. The write carries the stored 11-bit MSI value to the stored target address. The target is either a 34-bit byte address, held as a word address in a single register, or a full 64-bit address split over two registers. A build parameter picks the form. The response-suppress bit is only stored and brought out for the surrounding logic.

Top module: `viol_msi_regs`

## Requirements
- R1: After reset, every register reads zero, except that the MSI-enable bit reads the hardwired value when it is not programmable. `msi_valid_o` is 0.
- R2: The configuration register at offset 0x60 has this layout: bit 0 = lock, bit 1 = interrupt enable, bit 2 = response suppress (also driven on `cfg_suppress_o`), bit 3 = MSI enable, bits 18:8 = MSI data. Bits 7:4 and 31:19 always read zero.
- R3: A write with bit 0 = 1 sets the lock. While the lock is 1, writes to offsets 0x60, 0x78 and 0x7C change nothing, and only reset clears the lock.
- R4: While MSI enable is 0, the MSI data field and the address registers at 0x78 and 0x7C read zero, writes to them are dropped, and no write request is issued. A configuration write stores the MSI data only when the value it writes for MSI enable is 1.
- R5: With `HI_ADDR_EN`=0, the register at 0x78 holds byte-address bits 33:2. The request address is that value shifted left by two with bits 63:34 zero, and 0x7C reads zero.
- R6: With `HI_ADDR_EN`=1, 0x78 holds address bits 31:0 and 0x7C holds bits 63:32. Both read back what was written.
- R7: The request data is the 11-bit MSI value zero-extended to 32 bits.
- R8: A 0-to-1 transition of `viol_i`, seen while interrupt enable and MSI enable are both 1, launches exactly one request. Holding `viol_i` high launches no more requests.
- R9: A request keeps `msi_valid_o`, its address and its data stable until it is accepted with `msi_ready_i`. Further violation edges that occur while it is outstanding, including in the cycle it is accepted, are merged into it.
- R10: With interrupt enable 0, a violation edge launches no request.
- R11: With `MSI_EN_PROG`=0, the MSI enable bit always reads `MSI_EN_FIXED` and ignores writes.
- R12: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| viol_i | input | 1 | Violation indication from the checker |
| cfg_suppress_o | output | 1 | Stored response-suppress bit |
| msi_valid_o | output | 1 | MSI write request valid |
| msi_ready_i | input | 1 | MSI write request accepted |
| msi_addr_o | output | 64 | MSI byte address |
| msi_data_o | output | 32 | MSI write data |

## Verification
The bench builds two instances. The first uses `HI_ADDR_EN`=1 with a programmable MSI enable, which exercises the 64-bit split address, enabling and disabling MSI, the hiding of fields, merging under backpressure, and locking. The second uses `HI_ADDR_EN`=0 with the enable hardwired to 1. That instance brings within reach the 34-bit word-address shift, the absent high register and the write-immune enable bit.

// File: rtl/viol_msi_pkg.sv
package viol_msi_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned MDATA_W  = 11;
  localparam int unsigned MADDR_W  = 64;
  localparam int unsigned OFF_CFG  = 'h60;
  localparam int unsigned OFF_ALO  = 'h78;
  localparam int unsigned OFF_AHI  = 'h7C;
  localparam int unsigned B_LOCK   = 0;
  localparam int unsigned B_IRQEN  = 1;
  localparam int unsigned B_SUPP   = 2;
  localparam int unsigned B_MSIEN  = 3;
  localparam int unsigned B_MDATA  = 8;

  typedef struct packed {
    logic               lock;
    logic               irq_en;
    logic               suppress;
    logic               msi_en;
    logic [MDATA_W-1:0] mdata;
  } cfg_t;

  // Visible configuration word; data field hidden while MSI is off.
  function automatic logic [REG_W-1:0] cfg_word(input cfg_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_LOCK]  = c.lock;
    w[B_IRQEN] = c.irq_en;
    w[B_SUPP]  = c.suppress;
    w[B_MSIEN] = c.msi_en;
    if (c.msi_en) w[B_MDATA +: MDATA_W] = c.mdata;
    return w;
  endfunction

  // Byte address of the MSI target.
  function automatic logic [MADDR_W-1:0] msi_target(input bit wide,
                                                    input logic [REG_W-1:0] hi,
                                                    input logic [REG_W-1:0] lo);
    logic [MADDR_W-1:0] a;
    if (wide) a = {hi, lo};
    else      a = {{(MADDR_W-REG_W-2){1'b0}}, lo, 2'b00};
    return a;
  endfunction

  function automatic logic [REG_W-1:0] msi_payload(input logic [MDATA_W-1:0] d);
    return {{(REG_W-MDATA_W){1'b0}}, d};
  endfunction
endpackage

// File: rtl/viol_cfg_reg.sv
module viol_cfg_reg
  import viol_msi_pkg::*;
#(
  parameter bit MSI_EN_PROG  = 1'b1,
  parameter bit MSI_EN_FIXED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;
  logic next_en;
  logic unused_rsv;

  always_comb begin
    next_en = MSI_EN_PROG ? wdata[B_MSIEN] : MSI_EN_FIXED;
  end

  assign unused_rsv = ^{wdata[REG_W-1:B_MDATA+MDATA_W], wdata[B_MDATA-1:B_MSIEN+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.lock     <= 1'b0;
      cfg_q.irq_en   <= 1'b0;
      cfg_q.suppress <= 1'b0;
      cfg_q.msi_en   <= MSI_EN_PROG ? 1'b0 : MSI_EN_FIXED;
      cfg_q.mdata    <= '0;
    end else if (wr_en && !cfg_q.lock) begin
      cfg_q.lock     <= wdata[B_LOCK];
      cfg_q.irq_en   <= wdata[B_IRQEN];
      cfg_q.suppress <= wdata[B_SUPP];
      cfg_q.msi_en   <= next_en;
      if (next_en) cfg_q.mdata <= wdata[B_MDATA +: MDATA_W];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/viol_addr_reg.sv
module viol_addr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= '0;
    else if (wr_en) q_o <= wdata;
  end
endmodule

// File: rtl/viol_msi_launch.sv
module viol_msi_launch
  import viol_msi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               viol_i,
  input  logic               arm_i,
  input  logic [MADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]   data_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [MADDR_W-1:0] addr_o,
  output logic [REG_W-1:0]   data_o,
  output logic               fire_o,
  output logic               accept_o
);
  logic viol_q;
  logic rise;

  assign rise     = viol_i && !viol_q;
  assign fire_o   = rise && arm_i && !valid_o;
  assign accept_o = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_q  <= 1'b0;
      valid_o <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      viol_q <= viol_i;
      if (fire_o) begin
        valid_o <= 1'b1;
        addr_o  <= addr_i;
        data_o  <= data_i;
      end else if (accept_o) begin
        valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/viol_msi_regs.sv
module viol_msi_regs
  import viol_msi_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter bit          HI_ADDR_EN   = 1'b1,
  parameter bit          MSI_EN_PROG  = 1'b1,
  parameter bit          MSI_EN_FIXED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              viol_i,
  output logic              cfg_suppress_o,
  output logic              msi_valid_o,
  input  logic              msi_ready_i,
  output logic [63:0]       msi_addr_o,
  output logic [31:0]       msi_data_o
);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_ALO = ADDR_W'(OFF_ALO);
  localparam logic [ADDR_W-1:0] A_AHI = ADDR_W'(OFF_AHI);

  cfg_t             cfg;
  logic [REG_W-1:0] alo_q, ahi_q;
  logic             cfg_wr, alo_wr, ahi_wr, addr_open;
  logic             msi_fire, msi_accept, msi_arm;
  logic [REG_W-1:0] cfg_view;

  assign addr_open = !cfg.lock && cfg.msi_en;
  assign cfg_wr    = reg_we && (reg_addr == A_CFG);
  assign alo_wr    = reg_we && (reg_addr == A_ALO) && addr_open;
  assign ahi_wr    = reg_we && (reg_addr == A_AHI) && addr_open && HI_ADDR_EN;
  assign cfg_view  = cfg_word(cfg);
  assign msi_arm   = cfg.irq_en && cfg.msi_en;
  assign cfg_suppress_o = cfg.suppress;

  viol_cfg_reg #(.MSI_EN_PROG(MSI_EN_PROG), .MSI_EN_FIXED(MSI_EN_FIXED)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(reg_wdata), .cfg_o(cfg)
  );

  viol_addr_reg #(.W(REG_W)) u_alo (
    .clk(clk), .rst_n(rst_n), .wr_en(alo_wr), .wdata(reg_wdata), .q_o(alo_q)
  );

  generate
    if (HI_ADDR_EN) begin : g_hi
      viol_addr_reg #(.W(REG_W)) u_ahi (
        .clk(clk), .rst_n(rst_n), .wr_en(ahi_wr), .wdata(reg_wdata), .q_o(ahi_q)
      );
    end else begin : g_no_hi
      assign ahi_q = '0;
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CFG)                    reg_rdata = cfg_view;
    else if (reg_addr == A_ALO && cfg.msi_en) reg_rdata = alo_q;
    else if (reg_addr == A_AHI && cfg.msi_en && HI_ADDR_EN) reg_rdata = ahi_q;
  end

  viol_msi_launch u_launch (
    .clk(clk), .rst_n(rst_n), .viol_i(viol_i), .arm_i(msi_arm),
    .addr_i(msi_target(HI_ADDR_EN, ahi_q, alo_q)),
    .data_i(msi_payload(cfg.mdata)),
    .ready_i(msi_ready_i), .valid_o(msi_valid_o),
    .addr_o(msi_addr_o), .data_o(msi_data_o),
    .fire_o(msi_fire), .accept_o(msi_accept)
  );
endmodule

// File: rtl/viol_msi_regs_chk.sv
module viol_msi_regs_chk #(
  parameter bit HI_ADDR_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        msi_valid_o,
  input logic        msi_ready_i,
  input logic [63:0] msi_addr_o,
  input logic [31:0] msi_data_o,
  input logic        msi_accept,
  input logic [31:0] cfg_view,
  input logic        cfg_wr
);
  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_view[0] |=> cfg_view[0]);
  // R3
  locked_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_view[0] && cfg_wr) |=> $stable(cfg_view));
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid_o && !msi_ready_i) |=>
      (msi_valid_o && $stable(msi_addr_o) && $stable(msi_data_o)));
  // R8
  single_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_accept |=> !msi_valid_o);
  // R4
  msi_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_view[3] && !msi_valid_o) |=> !msi_valid_o);
  // R10
  irq_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_view[1] && !msi_valid_o) |=> !msi_valid_o);
  // R5
  narrow_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!HI_ADDR_EN && msi_valid_o) |-> (msi_addr_o[63:34] == '0 && msi_addr_o[1:0] == 2'b00));
  // R7
  data_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msi_valid_o |-> (msi_data_o[31:11] == '0));
endmodule

bind viol_msi_regs viol_msi_regs_chk #(.HI_ADDR_EN(HI_ADDR_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_valid_o(msi_valid_o), .msi_ready_i(msi_ready_i),
  .msi_addr_o(msi_addr_o), .msi_data_o(msi_data_o), .msi_accept(msi_accept),
  .cfg_view(cfg_view), .cfg_wr(cfg_wr)
);

// File: tb/viol_msi_regs_tb.sv
module viol_msi_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_a, rd_b;
  logic        viol_a = 1'b0, viol_b = 1'b0;
  logic        rdy_a = 1'b1, rdy_b = 1'b1;
  logic        sup_a, sup_b, val_a, val_b;
  logic [63:0] addr_a, addr_b;
  logic [31:0] data_a, data_b;
  int          n_chk = 0, n_fail = 0;
  logic [95:0] q_a[$];
  logic [95:0] q_b[$];

  always #5 clk = ~clk;

  viol_msi_regs #(.HI_ADDR_EN(1'b1), .MSI_EN_PROG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(we_a), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_a), .viol_i(viol_a), .cfg_suppress_o(sup_a), .msi_valid_o(val_a),
    .msi_ready_i(rdy_a), .msi_addr_o(addr_a), .msi_data_o(data_a));

  viol_msi_regs #(.HI_ADDR_EN(1'b0), .MSI_EN_PROG(1'b0), .MSI_EN_FIXED(1'b1)) u_dut_n (
    .clk(clk), .rst_n(rst_n), .reg_we(we_b), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rd_b), .viol_i(viol_b), .cfg_suppress_o(sup_b), .msi_valid_o(val_b),
    .msi_ready_i(rdy_b), .msi_addr_o(addr_b), .msi_data_o(data_b));

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; we_a = !b; we_b = b;
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
  endtask

  task automatic rd(input bit b, input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #2;
    check(req, b ? rd_b : rd_a, exp);
  endtask

  task automatic pulse(input bit b, input int cyc);
    @(negedge clk);
    if (b) viol_b = 1'b1; else viol_a = 1'b1;
    for (int i = 0; i < cyc; i++) @(negedge clk);
    viol_a = 1'b0; viol_b = 1'b0;
  endtask

  // Scoreboard monitors: pop and compare on each accepted request.
  always @(negedge clk) begin
    #2;
    if (rst_n && val_a && rdy_a) begin
      if (q_a.size() == 0) check("R8 unexpected MSI A", {addr_a, data_a}, '0);
      else check("R6 R7 R9 MSI A", {addr_a, data_a}, q_a.pop_front());
    end
    if (rst_n && val_b && rdy_b) begin
      if (q_b.size() == 0) check("R8 unexpected MSI B", {addr_b, data_b}, '0);
      else check("R5 R7 MSI B", {addr_b, data_b}, q_b.pop_front());
    end
  end

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 8'h60, 32'h0, "R1 cfg");
    rd(0, 8'h78, 32'h0, "R1 lo");
    rd(0, 8'h7C, 32'h0, "R1 hi");
    check("R1 valid", {95'b0, val_a}, 96'h0);
    rd(1, 8'h60, 32'h0000_0008, "R1 R11 cfg fixed enable");
    // R2 layout, reserved bits zero
    wr(0, 8'h60, 32'hFFFF_FFFE);
    rd(0, 8'h60, 32'h0007_FF0E, "R2 cfg readback");
    check("R2 suppress out", {95'b0, sup_a}, 96'h1);
    // R6 wide address
    wr(0, 8'h78, 32'h1234_5678);
    wr(0, 8'h7C, 32'h9ABC_DEF0);
    rd(0, 8'h78, 32'h1234_5678, "R6 lo");
    rd(0, 8'h7C, 32'h9ABC_DEF0, "R6 hi");
    // R9 backpressure with merge
    wr(0, 8'h60, 32'h0002_A50A);
    rdy_a = 1'b0;
    q_a.push_back({64'h9ABC_DEF0_1234_5678, 32'h0000_02A5});
    pulse(0, 1);
    #2; check("R8 launched", {95'b0, val_a}, 96'h1);
    pulse(0, 1);
    #2; check("R9 held addr", {32'b0, addr_a}, {32'b0, 64'h9ABC_DEF0_1234_5678});
    rdy_a = 1'b1;
    @(negedge clk); #2;
    check("R9 cleared after accept", {95'b0, val_a}, 96'h0);
    // R8 level held: one request
    q_a.push_back({64'h9ABC_DEF0_1234_5678, 32'h0000_02A5});
    pulse(0, 5);
    repeat (3) @(negedge clk);
    check("R8 one request", q_a.size(), 0);
    // R10 interrupt disabled
    wr(0, 8'h60, 32'h0002_A508);
    pulse(0, 1);
    #2; check("R10 no request", {95'b0, val_a}, 96'h0);
    // R4 MSI disabled
    wr(0, 8'h60, 32'h0000_0302);
    rd(0, 8'h60, 32'h0000_0002, "R4 data hidden");
    rd(0, 8'h78, 32'h0, "R4 lo hidden");
    rd(0, 8'h7C, 32'h0, "R4 hi hidden");
    wr(0, 8'h78, 32'h0000_FFFF);
    pulse(0, 1);
    #2; check("R4 no request", {95'b0, val_a}, 96'h0);
    wr(0, 8'h60, 32'h0000_0A0A);
    rd(0, 8'h78, 32'h1234_5678, "R4 write dropped");
    // R12 unmapped
    rd(0, 8'h40, 32'h0, "R12 unmapped");
    // R3 lock
    wr(0, 8'h60, 32'h0000_0A0B);
    rd(0, 8'h60, 32'h0000_0A0B, "R3 lock set");
    wr(0, 8'h60, 32'h0);
    rd(0, 8'h60, 32'h0000_0A0B, "R3 cfg frozen");
    wr(0, 8'h78, 32'h0);
    wr(0, 8'h7C, 32'h0);
    rd(0, 8'h78, 32'h1234_5678, "R3 lo frozen");
    rd(0, 8'h7C, 32'h9ABC_DEF0, "R3 hi frozen");
    q_a.push_back({64'h9ABC_DEF0_1234_5678, 32'h0000_000A});
    pulse(0, 1);
    // R11 R5 R7 narrow instance
    wr(1, 8'h60, 32'h0000_7F02);
    rd(1, 8'h60, 32'h0000_7F0A, "R11 enable fixed");
    wr(1, 8'h78, 32'h4000_0001);
    rd(1, 8'h78, 32'h4000_0001, "R5 lo");
    wr(1, 8'h7C, 32'hFFFF_FFFF);
    rd(1, 8'h7C, 32'h0, "R5 no hi");
    q_b.push_back({64'h0000_0001_0000_0004, 32'h0000_007F});
    pulse(1, 1);
    repeat (4) @(negedge clk);
    check("R8 queue A drained", q_a.size(), 0);
    check("R5 queue B drained", q_b.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule